// File: doc/BRIEF.md
# Exhaustive PLL Divider Search Engine

This block chooses the settings of a programmable clock synthesizer. Given a requested pixel frequency in hundredths of a megahertz, it picks a power-of-two post-divider exponent and a feedback/reference divider pair. The pair is the one whose synthesized output comes nearest the request. The synthesized output is modelled in a fixed-point scale with eight fractional bits, derived from a 14.31818 MHz crystal. The engine then packs the three values into a 16-bit program word. A controller pulses `start_i` with the target on `target_i` and waits for the one-cycle `done_o` pulse. `word_o` then holds the answer until the next accepted request.

The search is a plain nested scan over every legal divider pair: the reference divider is the outer loop and the feedback divider the inner loop. Each candidate's output must be divided by the reference divider. A multi-cycle restoring divider runs twice per outer step, once for the per-step increment and once for the starting value. Every inner step then advances the quotient and remainder incrementally, so each candidate costs a single cycle.

Top module: `pll_mn_search`

## Requirements
- R1: After reset `word_o` is 0 and `done_o` is 0.
- R2: A request with target 0 gives `word_o` = 0x00E0 with `done_o` high on the first clock edge after the request.
- R3: A nonzero target below 8000 is handled exactly as a target of 8000.
- R4: A target above 15938 is handled exactly as a target of 15938.
- R5: The comparison reference is the clamped target times 256 divided by 100, truncated.
- R6: The exponent k counts the doublings of the clamped target until it is no longer below 64000; k sits in word bits 7:6.
- R7: The reference divider M lies in 2..30 and sits in word bits 5:0; the feedback divider N lies in 35..247 and sits in word bits 15:8.
- R8: A candidate's output is floor(938356·(N+8) / (2^k·256·(M+2))). The chosen pair minimises the absolute difference to the reference. Only a strictly smaller error replaces the held best, so ties go to the lowest M and then the lowest N.
- R9: `done_o` is high for exactly one cycle per request, and `word_o` changes only on that cycle.
- R10: A `start_i` pulse while a search is running is ignored; the running search finishes with its own result and gives one `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| target_i | input | TGT_W (16) | Target frequency in 0.01 MHz units |
| word_o | output | 16 | Packed program word {N, k, M} |
| done_o | output | 1 | One-cycle result pulse |

## Verification
Targets inside the legal window at its two ends and at scattered interior points are each compared against an independently computed brute-force scan. A mistake in the candidate arithmetic, the error comparison or the tie rule shifts at least one of these words. Targets far below and far above the window must reproduce the words of the window's edges, which separates clamping from the doubling step. The zero target checks the short path and its latency. A second request issued mid-search checks that the running search keeps its target and produces a single pulse, and an idle period with a changing target checks that the word is held.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned MW        = 6;
  localparam int unsigned NW        = 8;
  localparam int unsigned K_MAX     = 3;
  localparam int unsigned KW        = $clog2(K_MAX + 1);
  localparam int unsigned FRAC_BITS = 8;
  localparam logic [DW-1:0] XTAL_SCALED = 32'd938356;
  localparam int unsigned M_LO   = 2;
  localparam int unsigned M_HI   = 30;
  localparam int unsigned N_LO   = 35;
  localparam int unsigned N_HI   = 247;
  localparam int unsigned N_BIAS = 8;
  localparam int unsigned M_BIAS = 2;
  localparam int unsigned F_LO   = 8000;
  localparam int unsigned F_HI   = 15938;
  localparam logic [DW-1:0] XTAL_BASE = XTAL_SCALED * (N_LO + N_BIAS);
  localparam logic [WORD_W-1:0] ZERO_WORD = 16'h00E0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STEP, ST_BASE, ST_SCAN, ST_PACK
  } srch_state_t;
endpackage

// File: rtl/pllsrch_divider.sv
module pllsrch_divider
  import pll_srch_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         fin_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  quo_q, quo_d, rem_q, rem_d, den_q, den_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, fin_q, fin_d;
  logic [W:0]    trial;

  always_comb begin
    quo_d  = quo_q;
    rem_d  = rem_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    fin_d  = 1'b0;
    trial  = {rem_q, quo_q[W-1]};
    if (go_i) begin
      quo_d  = num_i;
      rem_d  = '0;
      den_d  = den_i;
      cnt_d  = CW'(W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (trial >= {1'b0, den_q}) begin
        rem_d = W'(trial - {1'b0, den_q});
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = trial[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      fin_q  <= fin_d;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
  assign fin_o = fin_q;

  // R8: a finished division leaves a remainder below the divisor
  assert_rem_below_den_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (rem_q < den_q));
  // R10: the controller never restarts a division that is still running
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_q);
endmodule

// File: rtl/pllsrch_prep.sv
module pllsrch_prep
  import pll_srch_pkg::*;
#(
  parameter int unsigned TGT_W = 16
) (
  input  logic [TGT_W-1:0] tgt_i,
  output logic             zero_o,
  output logic [DW-1:0]    ref_o,
  output logic [KW-1:0]    k_o
);
  logic [DW-1:0] clamped, scaled;

  always_comb begin
    clamped = DW'(tgt_i);
    if (clamped < DW'(F_LO)) clamped = DW'(F_LO);
    if (clamped > DW'(F_HI)) clamped = DW'(F_HI);
    ref_o = (clamped << FRAC_BITS) / DW'(100);
    scaled = clamped;
    k_o = '0;
    for (int i = 0; i < int'(K_MAX); i++) begin
      if (scaled < DW'(F_LO << K_MAX)) begin
        scaled = scaled << 1;
        k_o    = k_o + KW'(1);
      end
    end
  end

  assign zero_o = (tgt_i == '0);
endmodule

// File: rtl/pllsrch_best.sv
module pllsrch_best
  import pll_srch_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [DW-1:0] ref_i,
  input  logic [DW-1:0] fout_i,
  input  logic [MW-1:0] m_i,
  input  logic [NW-1:0] n_i,
  output logic [MW-1:0] best_m_o,
  output logic [NW-1:0] best_n_o
);
  logic [DW-1:0] err_q, err_d, diff;
  logic [MW-1:0] m_q, m_d;
  logic [NW-1:0] n_q, n_d;

  always_comb begin
    diff = (ref_i > fout_i) ? (ref_i - fout_i) : (fout_i - ref_i);
    err_d = err_q;
    m_d   = m_q;
    n_d   = n_q;
    if (clr_i) begin
      err_d = '1;
      m_d   = '0;
      n_d   = '0;
    end else if (en_i && (diff < err_q)) begin
      err_d = diff;
      m_d   = m_i;
      n_d   = n_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '1;
      m_q   <= '0;
      n_q   <= '0;
    end else begin
      err_q <= err_d;
      m_q   <= m_d;
      n_q   <= n_d;
    end
  end

  assign best_m_o = m_q;
  assign best_n_o = n_q;

  // R8: the held best error never grows while candidates are scanned
  assert_best_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i) |=> (err_q <= $past(err_q)));
endmodule

// File: rtl/pll_mn_search.sv
module pll_mn_search
  import pll_srch_pkg::*;
#(
  parameter int unsigned TGT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [TGT_W-1:0]  target_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  srch_state_t st_q, st_d;
  logic [MW-1:0]     m_q, m_d, best_m;
  logic [NW-1:0]     n_q, n_d, best_n;
  logic [KW-1:0]     k_q, k_d, prep_k;
  logic [DW-1:0]     ref_q, ref_d, prep_ref;
  logic [DW-1:0]     qacc_q, qacc_d, racc_q, racc_d;
  logic [DW-1:0]     qstp_q, qstp_d, rstp_q, rstp_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              done_q, done_d, prep_zero;
  logic              div_go, div_fin, trk_clr, trk_en;
  logic [DW-1:0]     div_num, div_den, div_quo, div_rem;
  logic [DW-1:0]     den_cur, rsum, fout;

  pllsrch_prep #(.TGT_W(TGT_W)) prep_i (
    .tgt_i (target_i), .zero_o(prep_zero), .ref_o(prep_ref), .k_o(prep_k)
  );

  pllsrch_divider #(.W(DW)) div_i (
    .clk(clk), .rst_n(rst_n), .go_i(div_go), .num_i(div_num), .den_i(div_den),
    .quo_o(div_quo), .rem_o(div_rem), .fin_o(div_fin)
  );

  assign den_cur = DW'(m_q) + DW'(M_BIAS);
  assign rsum    = racc_q + rstp_q;
  assign fout    = qacc_q >> (DW'(k_q) + DW'(FRAC_BITS));
  assign div_den = DW'(m_d) + DW'(M_BIAS);

  pllsrch_best best_i (
    .clk(clk), .rst_n(rst_n), .clr_i(trk_clr), .en_i(trk_en),
    .ref_i(ref_q), .fout_i(fout), .m_i(m_q), .n_i(n_q),
    .best_m_o(best_m), .best_n_o(best_n)
  );

  always_comb begin
    st_d    = st_q;
    m_d     = m_q;
    n_d     = n_q;
    k_d     = k_q;
    ref_d   = ref_q;
    qacc_d  = qacc_q;
    racc_d  = racc_q;
    qstp_d  = qstp_q;
    rstp_d  = rstp_q;
    word_d  = word_q;
    done_d  = 1'b0;
    div_go  = 1'b0;
    div_num = XTAL_SCALED;
    trk_clr = 1'b0;
    trk_en  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (prep_zero) begin
            word_d = ZERO_WORD;
            done_d = 1'b1;
          end else begin
            ref_d   = prep_ref;
            k_d     = prep_k;
            m_d     = MW'(M_LO);
            div_go  = 1'b1;
            trk_clr = 1'b1;
            st_d    = ST_STEP;
          end
        end
      end
      ST_STEP: begin
        if (div_fin) begin
          qstp_d  = div_quo;
          rstp_d  = div_rem;
          div_num = XTAL_BASE;
          div_go  = 1'b1;
          st_d    = ST_BASE;
        end
      end
      ST_BASE: begin
        if (div_fin) begin
          qacc_d = div_quo;
          racc_d = div_rem;
          n_d    = NW'(N_LO);
          st_d   = ST_SCAN;
        end
      end
      ST_SCAN: begin
        trk_en = 1'b1;
        if (rsum >= den_cur) begin
          racc_d = rsum - den_cur;
          qacc_d = qacc_q + qstp_q + DW'(1);
        end else begin
          racc_d = rsum;
          qacc_d = qacc_q + qstp_q;
        end
        n_d = n_q + NW'(1);
        if (n_q == NW'(N_HI)) begin
          if (m_q == MW'(M_HI)) begin
            st_d = ST_PACK;
          end else begin
            m_d    = m_q + MW'(1);
            div_go = 1'b1;
            st_d   = ST_STEP;
          end
        end
      end
      ST_PACK: begin
        word_d = (WORD_W'(best_n) << 8) + (WORD_W'(k_q) << 6) + WORD_W'(best_m);
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      m_q    <= '0;
      n_q    <= '0;
      k_q    <= '0;
      ref_q  <= '0;
      qacc_q <= '0;
      racc_q <= '0;
      qstp_q <= '0;
      rstp_q <= '0;
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      m_q    <= m_d;
      n_q    <= n_d;
      k_q    <= k_d;
      ref_q  <= ref_d;
      qacc_q <= qacc_d;
      racc_q <= racc_d;
      qstp_q <= qstp_d;
      rstp_q <= rstp_d;
      word_q <= word_d;
      done_q <= done_d;
    end
  end

  assign word_o = word_q;
  assign done_o = done_q;

  // R2: zero target answers on the next edge
  assert_zero_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start_i && target_i == '0) |=> (done_q && word_q == ZERO_WORD));
  // R7: packed fields stay inside the scan ranges
  assert_fields_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && word_q != ZERO_WORD) |->
      (word_q[5:0] >= 6'(M_LO) && word_q[5:0] <= 6'(M_HI) &&
       word_q[15:8] >= 8'(N_LO) && word_q[15:8] <= 8'(N_HI)));
  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: the word moves only together with done
  assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(word_q));
  // R10: the scan index stays in range while scanning
  assert_scan_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SCAN) |-> (n_q >= NW'(N_LO) && n_q <= NW'(N_HI) && m_q <= MW'(M_HI)));
endmodule

// File: tb/pll_mn_search_tb.sv
module pll_mn_search_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 190000;
  localparam int WAIT_MAX   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [15:0] target_i;
  logic [15:0] word_o;
  logic        done_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit reported = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_mn_search #(.TGT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_i(target_i),
    .word_o(word_o), .done_o(done_o)
  );

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !reported) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected below %0d", cyc, WDOG);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int unsigned golden(input int unsigned t);
    int unsigned c, r, v, k, best, f, d, bm, bn, a, b;
    if (t == 0) return 32'h00E0;
    c = t;
    if (c < 8000) c = 8000;
    if (c > 15938) c = 15938;
    r = c * 256 / 100;
    v = c; k = 0;
    while (v < 64000) begin v = v * 2; k++; end
    best = 32'hFFFF_FFFF; bm = 0; bn = 0;
    for (int m = 2; m <= 30; m++) begin
      for (int n = 35; n <= 247; n++) begin
        a = 938356 * (n + 8);
        b = (1 << k) * 256 * (m + 2);
        f = a / b;
        d = (r > f) ? r - f : f - r;
        if (d < best) begin best = d; bm = m; bn = n; end
      end
    end
    return (k << 6) + bm + (bn << 8);
  endfunction

  task automatic issue(input logic [15:0] t);
    @(negedge clk);
    start_i  = 1'b1;
    target_i = t;
    @(negedge clk);
    start_i  = 1'b0;
  endtask

  task automatic await_done(output bit seen, output int waited);
    seen = 0; waited = 0;
    while (!seen && waited < WAIT_MAX) begin
      if (done_o) seen = 1;
      else begin @(negedge clk); waited++; end
    end
  endtask

  task automatic run_search(input logic [15:0] t, input string req, output logic [15:0] w);
    bit seen; int waited;
    int unsigned exp;
    exp = golden(t);
    issue(t);
    await_done(seen, waited);
    chk(seen, {req, " done seen"}, seen, 1);
    w = word_o;
    chk(w == exp[15:0], {req, " word"}, w, exp);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
  endtask

  task automatic test_reset();
    chk(word_o == 16'h0, "R1 reset word", word_o, 0);
    chk(done_o == 1'b0, "R1 reset done", done_o, 0);
  endtask

  task automatic test_zero();
    issue(16'd0);
    chk(done_o == 1'b1, "R2 zero latency", done_o, 1);
    chk(word_o == 16'h00E0, "R2 zero word", word_o, 16'h00E0);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 zero pulse", done_o, 0);
  endtask

  task automatic test_inside();
    logic [15:0] w;
    run_search(16'd10000, "R8 t=10000", w);
    chk(w[7:6] == 2'd3, "R6 k field", w[7:6], 3);
    chk(w[5:0] >= 2 && w[5:0] <= 30 && w[15:8] >= 35 && w[15:8] <= 247,
        "R7 field ranges", w, 0);
    run_search(16'd12587, "R8 t=12587", w);
    run_search(16'd9001,  "R5 t=9001", w);
  endtask

  task automatic test_edges();
    logic [15:0] wlo, whi, w;
    run_search(16'd8000,  "R3 t=8000", wlo);
    run_search(16'd15938, "R4 t=15938", whi);
    run_search(16'd100,   "R3 t=100", w);
    chk(w == wlo, "R3 low clamp equals edge", w, wlo);
    run_search(16'd40000, "R4 t=40000", w);
    chk(w == whi, "R4 high clamp equals edge", w, whi);
  endtask

  task automatic test_hold();
    logic [15:0] w0;
    w0 = word_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      target_i = 16'(i * 777);
    end
    chk(word_o == w0 && done_o == 1'b0, "R9 word held while idle", word_o, w0);
  endtask

  task automatic test_busy_start();
    bit seen; int waited; int dones;
    int unsigned exp;
    exp = golden(16'd11111);
    issue(16'd11111);
    repeat (500) @(negedge clk);
    issue(16'd0);
    chk(done_o == 1'b0, "R10 zero ignored while busy", done_o, 0);
    await_done(seen, waited);
    chk(seen && word_o == exp[15:0], "R10 running search result", word_o, exp);
    dones = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done_o) dones++;
    end
    chk(dones == 0, "R10 single done", dones, 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; target_i = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_zero();
    test_inside();
    test_edges();
    test_hold();
    test_busy_start();
    report();
    $finish;
  end
endmodule